// File: doc/BRIEF.md
# Ripple-Synchronized Window Override Controller

This block decides when the fast transient loop of a voltage-mode buck controller takes the power switches away from the main PWM loop. Two comparator flags report whether the feedback voltage is more than 3% above or more than 3% below the 1.25 V reference. They are not sampled freely. The "low" flag is taken only on the PWM reset pulse, which ends the on-time and so marks the inductor current peak. The "high" flag is taken only on the PWM set pulse, which starts the on-time and so marks the current valley. The output therefore counts as low only when even the ripple peak is below the window, and as high only when even the ripple trough is above it.

A captured low latches a 100% duty override (`force_on`). A captured high latches a 0% duty override (`force_off`). The override stays latched when the voltage re-enters the window. It is released only when the feedback crosses the regulation point. The controller runs only while `enable` is high. `enable` is driven once soft start has passed its 2.0 V level, and the controller also requires `fault` to be low. Otherwise every latch is cleared.

The state machine has four states:
- `ST_IDLE`: gated off.
- `ST_TRACK`: main loop in control, armed.
- `ST_HOLD_ON`: forcing the switch on.
- `ST_HOLD_OFF`: forcing the switch off.

It has these transitions:
- gate: any state goes to `ST_IDLE` when not active.
- capture-low: `ST_IDLE` or `ST_TRACK` goes to `ST_HOLD_ON`.
- capture-high: `ST_IDLE` or `ST_TRACK` goes to `ST_HOLD_OFF`.
- arm: an active `ST_IDLE` with no capture goes to `ST_TRACK`.
- release: either hold state goes to `ST_TRACK` on `ref_cross`.

Top module: `win_override_ctrl`

## Requirements
- R1: Out of reset, both `force_on` and `force_off` are 0.
- R2: With `enable`=1 and `fault`=0 and no override held, a clock edge that sees `reset_pulse`=1 together with `win_low`=1 makes `force_on` 1 from that edge on.
- R3: With `enable`=1 and `fault`=0 and no override held, a clock edge that sees `set_pulse`=1 together with `win_high`=1 makes `force_off` 1 from that edge on.
- R4: A window flag never captures unless its own pulse accompanies it. `win_low` with no `reset_pulse` has no effect, and neither has `win_low` with only `set_pulse`. `win_high` with no `set_pulse` has no effect, and neither has `win_high` with only `reset_pulse`.
- R5: A latched override stays at 1 on every edge without `ref_cross`, even after its window flag has cleared and further pulses arrive.
- R6: An edge with `ref_cross`=1 releases a latched override, so both outputs read 0 from that edge on and the block is re-armed. `ref_cross` with no override held has no effect.
- R7: `force_on` and `force_off` are never 1 together. When both capture conditions occur on one edge, the low capture wins and `force_on` is set. A held override blocks capture of the opposite one.
- R8: While `enable`=0 or `fault`=1, both outputs are 0 from the next edge on, any held override is cleared and no capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Soft start has reached its enable level |
| fault | input | 1 | Fault latch set; gates the block off |
| set_pulse | input | 1 | PWM on-time start (current valley) |
| reset_pulse | input | 1 | PWM on-time end (current peak) |
| win_low | input | 1 | Feedback more than 3% below reference |
| win_high | input | 1 | Feedback more than 3% above reference |
| ref_cross | input | 1 | Feedback crossed the regulation point |
| force_on | output | 1 | 100% duty override |
| force_off | output | 1 | 0% duty override |

## Verification
The outputs decode the state register directly, so a wrong state is visible at `force_on` and `force_off` in the same cycle it is entered. An override latched without its matching pulse shows up one edge after the stray flag. So does a release without `ref_cross`, and so does a hold that survives a fault. A tie resolved the wrong way shows as `force_off` right after the tie. The directed scenarios drive each of these situations and compare the two outputs on the edge that follows.

// File: rtl/win_override_pkg.sv
package win_override_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_TRACK    = 2'd1,
        ST_HOLD_ON  = 2'd2,
        ST_HOLD_OFF = 2'd3
    } wov_state_t;

    typedef struct packed {
        logic grab_low;
        logic grab_high;
    } wov_capture_t;

endpackage

// File: rtl/win_edge_qual.sv
module win_edge_qual #(
    parameter bit LOW_WINS = 1'b1
) (
    input  logic set_pulse,
    input  logic reset_pulse,
    input  logic win_low,
    input  logic win_high,
    output win_override_pkg::wov_capture_t cap
);
    import win_override_pkg::*;

    logic peak_low;
    logic valley_high;

    // low is judged at the current peak, high at the current valley
    assign peak_low    = reset_pulse & win_low;
    assign valley_high = set_pulse & win_high;

    generate
        if (LOW_WINS) begin : g_low_first
            always_comb begin
                cap.grab_low  = peak_low;
                cap.grab_high = valley_high & ~peak_low;
            end
        end else begin : g_high_first
            always_comb begin
                cap.grab_high = valley_high;
                cap.grab_low  = peak_low & ~valley_high;
            end
        end
    endgenerate

endmodule

// File: rtl/win_override_fsm.sv
module win_override_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_cross,
    input  win_override_pkg::wov_capture_t cap,
    output logic force_on,
    output logic force_off
);
    import win_override_pkg::*;

    wov_state_t state_q;
    wov_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_TRACK: begin
                    if (cap.grab_low)
                        state_d = ST_HOLD_ON;
                    else if (cap.grab_high)
                        state_d = ST_HOLD_OFF;
                    else
                        state_d = ST_TRACK;
                end
                ST_HOLD_ON: begin
                    if (ref_cross)
                        state_d = ST_TRACK;
                end
                ST_HOLD_OFF: begin
                    if (ref_cross)
                        state_d = ST_TRACK;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        force_on  = 1'b0;
        force_off = 1'b0;
        unique case (state_q)
            ST_HOLD_ON:  force_on  = 1'b1;
            ST_HOLD_OFF: force_off = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/win_override_ctrl.sv
module win_override_ctrl #(
    parameter bit LOW_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fault,
    input  logic set_pulse,
    input  logic reset_pulse,
    input  logic win_low,
    input  logic win_high,
    input  logic ref_cross,
    output logic force_on,
    output logic force_off
);
    import win_override_pkg::*;

    wov_capture_t cap;
    logic         active;

    assign active = enable & ~fault;

    win_edge_qual #(.LOW_WINS(LOW_WINS)) u_qual (
        .set_pulse   (set_pulse),
        .reset_pulse (reset_pulse),
        .win_low     (win_low),
        .win_high    (win_high),
        .cap         (cap)
    );

    win_override_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ref_cross (ref_cross),
        .cap       (cap),
        .force_on  (force_on),
        .force_off (force_off)
    );

endmodule

// File: rtl/win_override_checker.sv
module win_override_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fault,
    input logic set_pulse,
    input logic reset_pulse,
    input logic win_low,
    input logic win_high,
    input logic ref_cross,
    input logic force_on,
    input logic force_off
);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_on && force_off));

    p_on_needs_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_on) |-> $past(reset_pulse && win_low));

    p_off_needs_valley_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_off) |-> $past(set_pulse && win_high));

    p_hold_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on && enable && !fault && !ref_cross) |=> force_on);

    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && enable && !fault && !ref_cross) |=> force_off);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((force_on || force_off) && ref_cross) |=> !(force_on || force_off));

    p_gate_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || fault) |=> (!force_on && !force_off));

endmodule

bind win_override_ctrl win_override_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .fault       (fault),
    .set_pulse   (set_pulse),
    .reset_pulse (reset_pulse),
    .win_low     (win_low),
    .win_high    (win_high),
    .ref_cross   (ref_cross),
    .force_on    (force_on),
    .force_off   (force_off)
);

// File: tb/win_override_ctrl_test.sv
module win_override_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, fault = 1'b0;
    logic set_pulse = 1'b0, reset_pulse = 1'b0;
    logic win_low = 1'b0, win_high = 1'b0, ref_cross = 1'b0;
    logic force_on, force_off;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    win_override_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
        .set_pulse(set_pulse), .reset_pulse(reset_pulse),
        .win_low(win_low), .win_high(win_high), .ref_cross(ref_cross),
        .force_on(force_on), .force_off(force_off)
    );

    task automatic chk(input string req, input logic exp_on, input logic exp_off);
        n_checks++;
        if (force_on !== exp_on || force_off !== exp_off) begin
            n_fail++;
            $display("FAIL %s: on/off actual %b/%b expected %b/%b",
                     req, force_on, force_off, exp_on, exp_off);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, sample 1 ns later
    task automatic step(input logic en, input logic flt, input logic sp,
                        input logic rp, input logic wl, input logic wh,
                        input logic rc);
        @(negedge clk);
        enable = en; fault = flt; set_pulse = sp; reset_pulse = rp;
        win_low = wl; win_high = wh; ref_cross = rc;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R1 after reset", 1'b0, 1'b0);
    endtask

    task automatic t_low_capture;
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R2 low at peak", 1'b1, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 release on", 1'b0, 1'b0);
    endtask

    task automatic t_high_capture;
        step(1, 0, 1, 0, 0, 1, 0);
        chk("R3 high at valley", 1'b0, 1'b1);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 release off", 1'b0, 1'b0);
    endtask

    task automatic t_between_edges;
        step(1, 0, 0, 0, 1, 0, 0);
        chk("R4 low no pulse", 1'b0, 1'b0);
        step(1, 0, 0, 0, 0, 1, 0);
        chk("R4 high no pulse", 1'b0, 1'b0);
        step(1, 0, 1, 0, 1, 0, 0);
        chk("R4 low at valley", 1'b0, 1'b0);
        step(1, 0, 0, 1, 0, 1, 0);
        chk("R4 high at peak", 1'b0, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 cross idle", 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R2 capture for hold", 1'b1, 1'b0);
        step(1, 0, 0, 1, 0, 0, 0);
        chk("R5 hold window left", 1'b1, 1'b0);
        step(1, 0, 1, 0, 0, 1, 0);
        chk("R7 no opposite capture", 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1, 0, i[0], ~i[0], 0, 0, 0);
        chk("R5 hold over pulses", 1'b1, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 release after hold", 1'b0, 1'b0);
        step(1, 0, 1, 0, 0, 1, 0);
        chk("R6 rearmed", 1'b0, 1'b1);
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R5 off held vs low", 1'b0, 1'b1);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 release off2", 1'b0, 1'b0);
    endtask

    task automatic t_tie;
        step(1, 0, 1, 1, 1, 1, 0);
        chk("R7 tie low wins", 1'b1, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R6 release tie", 1'b0, 1'b0);
    endtask

    task automatic t_gate;
        step(0, 0, 0, 1, 1, 0, 0);
        chk("R8 disabled no capture", 1'b0, 1'b0);
        step(1, 1, 1, 0, 0, 1, 0);
        chk("R8 fault no capture", 1'b0, 1'b0);
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R8 capture before fault", 1'b1, 1'b0);
        step(1, 1, 0, 0, 0, 0, 0);
        chk("R8 fault clears", 1'b0, 1'b0);
        step(1, 0, 1, 0, 0, 1, 0);
        chk("R8 capture before disable", 1'b0, 1'b1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R8 disable clears", 1'b0, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R8 stays clear on re-enable", 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_low_capture();
        t_high_capture();
        t_between_edges();
        t_hold();
        t_tie();
        t_gate();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule